// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the slave side of a serial peripheral interface in front of a small byte-addressed memory. The memory is held in on-chip registers. Chip select, serial clock, serial input and a pause input arrive from the pins. Each is brought into the system clock domain through a two-stage synchroniser and then edge-detected. The serial output leaves as a data bit plus a separate drive enable, which the pad ring turns into a tri-state pin.

After a select edge the block shifts in an 8-bit opcode. It can then serve any of the following:
- a sequential read with address auto-increment;
- a status read;
- set or clear of the write-enable latch;
- a status write;
- a page write.

Write data collects in a page buffer and is committed when chip select rises. A self-timed busy period follows the commit. During that period only the status read is honoured. Serial clock modes 0 and 3 are both handled, and the serial clock must run at least four times slower than the system clock.

Top module: `serial_mem_cmd`

## Requirements
- R1: While chip select is high, or before any read data has been shifted, `so_oe` is low. After reset the status byte reads 0x00.
- R2: Input bits are taken on the rising serial clock edge and output bits change on the falling edge, MSB first. This holds in mode 0 (clock idles low) and in mode 3 (clock idles high).
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) when chip select rises. Opcode 0x04 clears it when chip select rises.
- R4: Opcode 0x03 followed by an address returns the byte at that address, then the following bytes. The address is 8 bits when AW is 8 or less, otherwise 16 bits, MSB first, and only the low AW bits are used. The address wraps from the top address to 0.
- R5: Opcode 0x02 followed by an address stores each complete data byte in a page buffer. The low log2(PAGE) address bits increment and wrap inside the page. The buffer is committed on the chip select rise only if the write-enable latch is set and at least one full byte arrived. A trailing partial byte is dropped.
- R6: A commit sets the busy flag (status bit 0) for WR_CYC system clocks and clears the write-enable latch.
- R7: While busy, every opcode other than 0x05 is ignored: it has no effect and drives no output. Opcode 0x05 still works.
- R8: Opcode 0x01 followed by a full byte updates only status bits 7, 3 and 2, and only if the write-enable latch is set. The update happens on the chip select rise, starts a busy period and clears the latch.
- R9: After an unknown opcode all further bits are ignored and `so_oe` stays low until the next chip select fall.
- R10: While the pause input is low, serial clock edges are ignored and `so_oe` is low. When it is raised again, the transfer continues at the same bit.
- R11: A command whose opcode is cut short by a chip select rise has no effect.
- R12: A status read keeps returning the status byte for every further byte clocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for the serial output |

## Verification
The bench writes a page across its wrap boundary. A design that increments the full address would instead spill the last bytes into the next page. It reads across the top address, where a missing wrap would return bytes from outside the array. It also issues a write-enable and a read while the busy period runs. A design that failed to gate on busy would set the latch or drive the bus there. Two further cases target the serial framing: a pause in the middle of a read byte, after which shifted bits would be lost or repeated, and a byte write ended three bits into its second data byte, which a careless commit would store as a corrupted byte.

// File: rtl/serial_mem_cmd.sv
module serial_mem_cmd #(
  parameter int AW     = 8,
  parameter int PAGE   = 16,
  parameter int WR_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int ABITS = (AW > 8) ? 16 : 8;
  localparam int PW    = $clog2(PAGE);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WR_CYC + 1);

  typedef enum logic [3:0] {
    P_IDLE, P_CMD, P_ADR, P_RD, P_WR, P_SRR, P_SRW, P_SRWD, P_WEN, P_WDI, P_IGN
  } phase_t;

  logic [2:0] sck_q, cs_q, hold_q;
  logic [1:0] si_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; hold_q <= '1; si_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q <= {cs_q[1:0], cs_n};
      hold_q <= {hold_q[1:0], hold_n};
      si_q <= {si_q[0], si};
    end

  wire cs_s    = cs_q[1];
  wire hold_s  = hold_q[1];
  wire si_s    = si_q[1];
  wire act     = ~cs_s & hold_s;
  wire rise    = sck_q[1] & ~sck_q[2] & act;
  wire fall    = ~sck_q[1] & sck_q[2] & act;
  wire cs_fall = cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];

  phase_t phase;
  logic [4:0] cnt;
  logic [7:0] sh, obuf;
  logic [ABITS-1:0] ash;
  logic [AW-1:0] addr;
  logic so_r, drv, wel, wpen, rd_op;
  logic [1:0] bp;
  logic [2:0] sr_new;
  logic [CW-1:0] bcnt;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pmask;

  wire busy = bcnt != '0;
  wire [7:0] status = {wpen, 3'b000, bp, wel, busy};
  wire [7:0] sh_n = {sh[6:0], si_s};
  wire [ABITS-1:0] ash_n = {ash[ABITS-2:0], si_s};
  wire byte_end = cnt[2:0] == 3'd7;
  wire [4:0] cnt_d = byte_end ? 5'd0 : cnt + 5'd1;
  wire [7:0] rd_byte = (phase == P_RD) ? mem[addr] : status;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_IDLE; cnt <= '0; sh <= '0; obuf <= '0; ash <= '0; addr <= '0;
      so_r <= 1'b0; drv <= 1'b0; wel <= 1'b0; wpen <= 1'b0; rd_op <= 1'b0;
      bp <= '0; sr_new <= '0; bcnt <= '0; pmask <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (cs_fall) begin
        phase <= P_CMD; cnt <= '0; drv <= 1'b0; pmask <= '0;
      end else if (cs_rise) begin
        phase <= P_IDLE; drv <= 1'b0;
        case (phase)
          P_WEN: wel <= 1'b1;
          P_WDI: wel <= 1'b0;
          P_SRWD: if (wel) begin
            {wpen, bp} <= sr_new; wel <= 1'b0; bcnt <= CW'(WR_CYC);
          end
          P_WR: if (wel && |pmask) begin
            for (int i = 0; i < PAGE; i++)
              if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
            wel <= 1'b0; bcnt <= CW'(WR_CYC);
          end
          default: ;
        endcase
      end else if (rise) begin
        case (phase)
          P_CMD: begin
            sh <= sh_n;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (busy && sh_n != 8'h05) phase <= P_IGN;
              else case (sh_n)
                8'h06: phase <= P_WEN;
                8'h04: phase <= P_WDI;
                8'h05: phase <= P_SRR;
                8'h01: phase <= P_SRW;
                8'h03: begin phase <= P_ADR; rd_op <= 1'b1; end
                8'h02: begin phase <= P_ADR; rd_op <= 1'b0; end
                default: phase <= P_IGN;
              endcase
            end
          end
          P_ADR: begin
            ash <= ash_n;
            cnt <= cnt + 5'd1;
            if (cnt == 5'(ABITS - 1)) begin
              cnt <= '0;
              addr <= ash_n[AW-1:0];
              phase <= rd_op ? P_RD : P_WR;
            end
          end
          P_RD: begin
            cnt <= cnt_d;
            if (byte_end) addr <= addr + 1'b1;
          end
          P_SRR: cnt <= cnt_d;
          P_WR: begin
            sh <= sh_n;
            cnt <= cnt_d;
            if (byte_end) begin
              pbuf[addr[PW-1:0]] <= sh_n;
              pmask[addr[PW-1:0]] <= 1'b1;
              addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
            end
          end
          P_SRW: begin
            sh <= sh_n;
            cnt <= cnt_d;
            if (byte_end) begin
              sr_new <= {sh_n[7], sh_n[3:2]};
              phase <= P_SRWD;
            end
          end
          P_WEN, P_WDI: phase <= P_IGN;
          default: ;
        endcase
      end else if (fall && (phase == P_RD || phase == P_SRR)) begin
        drv <= 1'b1;
        if (cnt[2:0] == 3'd0) begin
          so_r <= rd_byte[7];
          obuf <= {rd_byte[6:0], 1'b0};
        end else begin
          so_r <= obuf[7];
          obuf <= {obuf[6:0], 1'b0};
        end
      end
    end

  assign so    = so_r;
  assign so_oe = drv & ~cs_s & hold_s;
endmodule

// File: rtl/serial_mem_cmd_chk.sv
module serial_mem_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic so_oe,
  input logic busy,
  input logic wel,
  input logic xfer_ph,
  input logic ign_ph,
  input logic wen_ph
);
  p_oe_off_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !so_oe);
  p_wel_from_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wen_ph));
  p_commit_clears_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);
  p_no_access_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ph |-> !busy);
  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ign_ph |-> !so_oe);
  p_oe_off_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hold_n, 2) |-> !so_oe);
endmodule

bind serial_mem_cmd serial_mem_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .busy(busy), .wel(wel),
  .xfer_ph(phase == P_ADR || phase == P_RD || phase == P_WR || phase == P_WEN ||
           phase == P_WDI || phase == P_SRW || phase == P_SRWD),
  .ign_ph(phase == P_IGN),
  .wen_ph(phase == P_WEN)
);

// File: tb/sim_serial_mem_cmd.sv
module sim_serial_mem_cmd;
  localparam int HALF = 6;
  localparam int WRC  = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  serial_mem_cmd #(.AW(8), .PAGE(16), .WR_CYC(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe)
  );

  always #10 clk = ~clk;

  int ncmp = 0, nerr = 0;
  logic [7:0] mref [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [8];
  logic [7:0] rxb, st;
  logic oe_all, oe_any, wel_m;

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bitx(input logic b);
    sck = 1'b0; si = b; wt(HALF);
    rxb = {rxb[6:0], so}; oe_all &= so_oe; oe_any |= so_oe;
    sck = 1'b1; wt(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx);
    rxb = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) bitx(tx[i]);
  endtask

  task automatic start(input logic m3);
    sck = m3; wt(4); cs_n = 1'b0; wt(4);
  endtask

  task automatic stop(input logic m3);
    if (!m3) begin sck = 1'b0; wt(HALF); end
    cs_n = 1'b1; wt(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    start(1'b0); xfer(op); stop(1'b0);
  endtask

  task automatic rdsr(output logic [7:0] v);
    start(1'b0); xfer(8'h05); xfer(8'h00); v = rxb; stop(1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input int n);
    start(1'b0); xfer(8'h02); xfer(a);
    for (int k = 0; k < n; k++) xfer(wbuf[k]);
    stop(1'b0);
    if (wel_m && n > 0) begin
      for (int k = 0; k < n; k++) mref[{a[7:4], 4'(a[3:0] + k)}] = wbuf[k];
      wel_m = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, input int n, input logic m3);
    start(m3); xfer(8'h03); xfer(a);
    for (int k = 0; k < n; k++) begin xfer(8'h00); rbuf[k] = rxb; end
    stop(m3);
  endtask

  task automatic chk_rd(input string r, input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) chk(r, rbuf[k], mref[8'(a + k)]);
  endtask

  task automatic wren(); cmd1(8'h06); wel_m = 1'b1; endtask
  task automatic wait_ready(); wt(WRC + 20); endtask

  initial begin
    repeat (180000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mref[i] = 8'h00;
    wel_m = 1'b0;
    wt(5);
    chk("R1 oe at reset", so_oe, 1'b0);
    rst_n = 1'b1; wt(5);
    rdsr(st); chk("R1 status after reset", st, 8'h00);
    chk("R1 oe after deselect", so_oe, 1'b0);

    // R3 latch set and clear
    cmd1(8'h06); rdsr(st); chk("R3 enable sets bit1", st, 8'h02);
    cmd1(8'h04); rdsr(st); chk("R3 disable clears bit1", st, 8'h00);

    // R5 write without latch discarded
    wbuf[0] = 8'hAA; wr(8'h10, 1); wait_ready;
    rd(8'h10, 1, 1'b0); chk_rd("R5 no latch no write", 8'h10, 1);

    // R5 page wrap, R6 busy, R7 ignore during busy
    wren;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr(8'h3E, 4);
    rdsr(st); chk("R6 busy set and latch cleared", st, 8'h01);
    cmd1(8'h06);
    wait_ready;
    rdsr(st); chk("R7 enable ignored while busy", st, 8'h00);
    rd(8'h30, 2, 1'b0); chk_rd("R5 wrapped bytes at page start", 8'h30, 2);
    rd(8'h3E, 2, 1'b0); chk_rd("R4 sequential read", 8'h3E, 2);

    wren; wbuf[0] = 8'h5A; wr(8'hFF, 1);
    rd(8'hFF, 1, 1'b0); chk("R7 read while busy drives nothing", oe_any, 1'b0);
    wait_ready;
    rd(8'hFE, 4, 1'b0); chk_rd("R4 wrap from top address", 8'hFE, 4);

    // R2 mode 3
    rd(8'h3E, 3, 1'b1); chk_rd("R2 mode 3 read", 8'h3E, 3);
    chk("R2 oe held over data byte", oe_all, 1'b1);

    // R11 truncated opcode
    start(1'b0); for (int i = 0; i < 5; i++) bitx(1'b0); stop(1'b0);
    rdsr(st); chk("R11 truncated enable no effect", st, 8'h00);

    // R5 trailing partial byte dropped
    wren; start(1'b0); xfer(8'h02); xfer(8'h50); xfer(8'h77);
    bitx(1'b1); bitx(1'b0); bitx(1'b1); stop(1'b0);
    mref[8'h50] = 8'h77; wel_m = 1'b0; wait_ready;
    rd(8'h50, 2, 1'b0); chk_rd("R5 partial trailing byte dropped", 8'h50, 2);

    // R8 status write
    wren; start(1'b0); xfer(8'h01); xfer(8'hFF); stop(1'b0); wait_ready;
    rdsr(st); chk("R8 only bits 7,3,2 written", st, 8'h8C);
    start(1'b0); xfer(8'h01); xfer(8'h00); stop(1'b0); wait_ready;
    rdsr(st); chk("R8 no latch no status write", st, 8'h8C);
    cmd1(8'h06); start(1'b0); xfer(8'h01); xfer(8'h00); stop(1'b0); wait_ready;
    rdsr(st); chk("R8 status restored", st, 8'h00);

    // R9 unknown opcode
    start(1'b0); xfer(8'hFF); xfer(8'hA5); chk("R9 unknown opcode silent", oe_any, 1'b0);
    xfer(8'h05); chk("R9 later bits ignored", oe_any, 1'b0); stop(1'b0);
    rdsr(st); chk("R9 next select recovers", st, 8'h00);

    // R12 repeated status byte
    cmd1(8'h06);
    start(1'b0); xfer(8'h05); xfer(8'h00); chk("R12 first status byte", rxb, 8'h02);
    xfer(8'h00); chk("R12 repeated status byte", rxb, 8'h02); stop(1'b0);
    cmd1(8'h04);

    // R10 pause mid byte
    start(1'b0); xfer(8'h03); xfer(8'h3E);
    rxb = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < 4; i++) bitx(1'b0);
    sck = 1'b0; wt(HALF); hold_n = 1'b0; wt(6);
    chk("R10 output off while paused", so_oe, 1'b0);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; si = 1'b1; wt(HALF); sck = 1'b0; wt(HALF); end
    hold_n = 1'b1; wt(6);
    for (int i = 0; i < 4; i++) bitx(1'b0);
    chk("R10 byte intact across pause", rxb, mref[8'h3E]);
    xfer(8'h00); chk("R10 next byte after pause", rxb, mref[8'h3F]);
    stop(1'b0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom % 256);
      n = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) begin
        wren;
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        wr(a, n); wait_ready;
      end else begin
        rd(a, n, 1'($urandom % 2));
        chk_rd("R4 random read", a, n);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule